// File: doc/BRIEF.md
# Privileged Exception Entry and Interrupt Arbiter

This block decides, once per clock, whether the core must leave its current instruction stream. It accepts a synchronous exception request, which carries a cause code and, for call-traps, a trap number. It also watches four asynchronous interrupt lines: device, timer, inter-processor and machine check. An interrupt is taken only if the current interrupt priority level (IPL) leaves it unmasked and the core is not already running privileged code.

When an event is taken, the block computes the entry address from a privileged base register plus a per-cause offset. It saves the interrupted PC with the old privilege flag folded into bit 0, forces the mode flag to privileged and raises a one-cycle taken strobe. Call-traps are spread over two tables of 64-byte slots, selected by bit 7 of the trap number. An exception request with a cause code the block does not know raises an error strobe instead of redirecting the core.

All results are registered. The cycle after a taken event is a dead cycle in which requests are not accepted, so the core has time to apply the new mode before the next decision.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is high, taken and cause_err are 0, new_pc and exc_addr are 0, and priv_out is 1.
- R2: irq_pend bit 0 (device) is eligible at IPL 0..3. Bit 1 (timer) is eligible at IPL 0..4. Bit 2 (inter-processor) is eligible at IPL 0..5. Bit 3 (machine check) is eligible at IPL 0..6. No line is eligible at IPL 7.
- R3: Among eligible lines, machine check wins over inter-processor, which wins over timer, which wins over device. The entry offsets for these lines are 0x080, 0x100, 0x180 and 0x200 respectively.
- R4: No interrupt is taken while priv_mode is 1.
- R5: exc_cause codes 0..9 (reset, machine check, inter-processor, timer, device, memory fault, unaligned, illegal opcode, arithmetic, FP disabled) enter at base_addr + code*0x80.
- R6: exc_cause code 10 is a call-trap with number n. If n[7] is 1, it enters at base_addr + 0x2000 + (n-0x80)*64. Otherwise it enters at base_addr + 0x1000 + n*64. The sum wraps modulo 2^PC_W.
- R7: On a taken event, exc_addr equals cur_pc ORed with priv_mode in bit 0.
- R8: A taken event sets priv_out to 1. In any other cycle, priv_out is priv_mode as sampled at the previous edge.
- R9: A valid exception request is taken in preference to any pending interrupt in the same cycle.
- R10: taken is high for exactly one cycle. Requests presented in the cycle after a taken event are ignored.
- R11: An exception request with exc_cause 11..15 pulses cause_err, leaves new_pc and exc_addr unchanged, takes nothing (not even a pending interrupt), and does not set priv_out.
- R12: Every result appears at the outputs on the clock edge that samples the request, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 4 | Pending interrupts: bit 0 device, 1 timer, 2 inter-processor, 3 machine check |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 4 | Exception cause code |
| trap_num | input | 8 | Call-trap number, used for cause 10 |
| cur_pc | input | PC_W | PC of the interrupted stream |
| cur_ipl | input | IPL_W | Current interrupt priority level |
| priv_mode | input | 1 | Core is in privileged mode |
| base_addr | input | PC_W | Privileged entry base register |
| new_pc | output | PC_W | Entry-point address of the last taken event |
| exc_addr | output | PC_W | Saved return address with mode in bit 0 |
| priv_out | output | 1 | Updated mode flag |
| taken | output | 1 | One-cycle strobe for a taken event |
| cause_err | output | 1 | One-cycle strobe for an unknown cause code |

## Verification
Every output is a register loaded on the edge that samples the inputs, so each result is due one cycle after its stimulus. The bench drives on the falling edge and reads the outputs 1 ns after the next rising edge. After each vector it inserts one idle cycle, which clears the dead cycle that follows a taken event. The dead-cycle check itself applies a second request exactly one edge after the first. It then expects no strobe and an unchanged new_pc at that same sampling point.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int N_IRQ        = 4;
    localparam int CAUSE_W      = 4;
    localparam int TRAP_W       = 8;
    localparam int OFS_W        = 14;
    localparam int IRQ_BASE_IPL = 3;
    localparam int SLOT_SHIFT   = 7;
    localparam int TRAP_SHIFT   = 6;
    localparam logic [OFS_W-1:0] TRAP_TBL_LO = OFS_W'(14'h1000);
    localparam logic [OFS_W-1:0] TRAP_TBL_HI = OFS_W'(14'h2000);

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_RESET    = 4'd0,
        CAUSE_MCHK     = 4'd1,
        CAUSE_IPI      = 4'd2,
        CAUSE_TIMER    = 4'd3,
        CAUSE_DEVICE   = 4'd4,
        CAUSE_MEMFLT   = 4'd5,
        CAUSE_UNALIGN  = 4'd6,
        CAUSE_ILLOP    = 4'd7,
        CAUSE_ARITH    = 4'd8,
        CAUSE_FPOFF    = 4'd9,
        CAUSE_CALLTRAP = 4'd10
    } cause_e;

    typedef struct packed {
        logic                take;
        logic                err;
        logic [CAUSE_W-1:0]  code;
    } decision_t;

    // Interrupt line i maps to cause (device - i): 0 dev, 1 timer, 2 ipi, 3 mchk
    function automatic logic [CAUSE_W-1:0] irq_line_cause(input int idx);
        return CAUSE_W'(int'(CAUSE_DEVICE) - idx);
    endfunction

    function automatic logic [OFS_W-1:0] fixed_offset(input logic [CAUSE_W-1:0] c);
        return OFS_W'({c, {SLOT_SHIFT{1'b0}}});
    endfunction

    function automatic logic [OFS_W-1:0] calltrap_offset(input logic [TRAP_W-1:0] n);
        logic [OFS_W-1:0] slot;
        slot = OFS_W'({n[TRAP_W-2:0], {TRAP_SHIFT{1'b0}}});
        return (n[TRAP_W-1] ? TRAP_TBL_HI : TRAP_TBL_LO) + slot;
    endfunction

endpackage

// File: rtl/exc_irq_arb.sv
module exc_irq_arb
    import exc_entry_pkg::*;
#(
    parameter int IPL_W = 3
) (
    input  logic [N_IRQ-1:0]   pend,
    input  logic [IPL_W-1:0]   ipl,
    input  logic               priv,
    output logic               valid,
    output logic [CAUSE_W-1:0] cause
);

    logic [N_IRQ-1:0] elig;

    // Line g stays eligible up to IPL (IRQ_BASE_IPL + g)
    generate
        for (genvar g = 0; g < N_IRQ; g++) begin : g_elig
            assign elig[g] = pend[g] && !priv && (int'(ipl) <= IRQ_BASE_IPL + g);
        end
    endgenerate

    // Higher line index has higher priority; last match wins
    always_comb begin
        valid = 1'b0;
        cause = CAUSE_RESET;
        for (int i = 0; i < N_IRQ; i++) begin
            if (elig[i]) begin
                valid = 1'b1;
                cause = irq_line_cause(i);
            end
        end
    end

endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
    import exc_entry_pkg::*;
(
    input  logic [CAUSE_W-1:0] code,
    input  logic [TRAP_W-1:0]  trap_num,
    output logic               known,
    output logic [OFS_W-1:0]   offset
);

    always_comb begin
        known  = (code <= CAUSE_CALLTRAP);
        offset = (code == CAUSE_CALLTRAP) ? calltrap_offset(trap_num)
                                          : fixed_offset(code);
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IPL_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_IRQ-1:0]   irq_pend,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic [TRAP_W-1:0]  trap_num,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [IPL_W-1:0]   cur_ipl,
    input  logic               priv_mode,
    input  logic [PC_W-1:0]    base_addr,
    output logic [PC_W-1:0]    new_pc,
    output logic [PC_W-1:0]    exc_addr,
    output logic               priv_out,
    output logic               taken,
    output logic               cause_err
);

    logic               irq_valid;
    logic [CAUSE_W-1:0] irq_cause;
    logic [CAUSE_W-1:0] sel_code;
    logic               sel_known;
    logic [OFS_W-1:0]   sel_ofs;
    logic               dead_q;
    decision_t          dec;

    exc_irq_arb #(.IPL_W(IPL_W)) u_arb (
        .pend  (irq_pend),
        .ipl   (cur_ipl),
        .priv  (priv_mode),
        .valid (irq_valid),
        .cause (irq_cause)
    );

    assign sel_code = exc_req ? exc_cause : irq_cause;

    exc_vec_calc u_vec (
        .code     (sel_code),
        .trap_num (trap_num),
        .known    (sel_known),
        .offset   (sel_ofs)
    );

    // Exception first, then interrupt; nothing in the dead cycle
    always_comb begin
        dec = '{take: 1'b0, err: 1'b0, code: sel_code};
        if (!dead_q) begin
            if (exc_req) begin
                dec.take = sel_known;
                dec.err  = !sel_known;
            end else if (irq_valid) begin
                dec.take = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            new_pc    <= '0;
            exc_addr  <= '0;
            priv_out  <= 1'b1;
            taken     <= 1'b0;
            cause_err <= 1'b0;
            dead_q    <= 1'b0;
        end else begin
            taken     <= dec.take;
            cause_err <= dec.err;
            dead_q    <= dec.take;
            priv_out  <= dec.take ? 1'b1 : priv_mode;
            if (dec.take) begin
                new_pc   <= base_addr + PC_W'(sel_ofs);
                exc_addr <= {cur_pc[PC_W-1:1], cur_pc[0] | priv_mode};
            end
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IPL_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               exc_req,
    input logic [CAUSE_W-1:0] exc_cause,
    input logic [PC_W-1:0]    cur_pc,
    input logic [IPL_W-1:0]   cur_ipl,
    input logic               priv_mode,
    input logic [PC_W-1:0]    new_pc,
    input logic [PC_W-1:0]    exc_addr,
    input logic               priv_out,
    input logic               taken,
    input logic               cause_err
);

    p_taken_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        taken |=> !taken);

    p_priv_on_take_r8: assert property (@(posedge clk) disable iff (rst)
        taken |-> priv_out);

    p_priv_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (priv_mode && !exc_req) |=> priv_out);

    p_no_irq_in_priv_r4: assert property (@(posedge clk) disable iff (rst)
        (priv_mode && !exc_req) |=> !taken);

    p_top_ipl_masks_r2: assert property (@(posedge clk) disable iff (rst)
        ((&cur_ipl) && !exc_req) |=> !taken);

    p_err_excl_r11: assert property (@(posedge clk) disable iff (rst)
        cause_err |-> !taken);

    p_err_holds_pc_r11: assert property (@(posedge clk) disable iff (rst)
        cause_err |-> ($stable(new_pc) && $stable(exc_addr)));

    p_unknown_no_take_r11: assert property (@(posedge clk) disable iff (rst)
        (exc_req && exc_cause > CAUSE_CALLTRAP) |=> !taken);

    p_saved_mode_bit_r7: assert property (@(posedge clk) disable iff (rst)
        taken |-> (exc_addr[0] == ($past(cur_pc[0]) | $past(priv_mode))));

endmodule

bind exc_entry_unit exc_entry_chk #(.PC_W(PC_W), .IPL_W(IPL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .exc_req   (exc_req),
    .exc_cause (exc_cause),
    .cur_pc    (cur_pc),
    .cur_ipl   (cur_ipl),
    .priv_mode (priv_mode),
    .new_pc    (new_pc),
    .exc_addr  (exc_addr),
    .priv_out  (priv_out),
    .taken     (taken),
    .cause_err (cause_err)
);

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;

    localparam int PCW = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [3:0]     irq_pend = '0;
    logic           exc_req = 1'b0;
    logic [3:0]     exc_cause = '0;
    logic [7:0]     trap_num = '0;
    logic [PCW-1:0] cur_pc = '0;
    logic [2:0]     cur_ipl = '0;
    logic           priv_mode = 1'b0;
    logic [PCW-1:0] base_addr = '0;
    logic [PCW-1:0] new_pc, exc_addr;
    logic           priv_out, taken, cause_err;

    int checks = 0;
    int fails  = 0;
    logic [PCW-1:0] exp_pc = '0;
    logic [PCW-1:0] exp_ea = '0;

    always #5 clk = ~clk;

    exc_entry_unit #(.PC_W(PCW), .IPL_W(3)) u_dut (
        .clk(clk), .rst(rst), .irq_pend(irq_pend), .exc_req(exc_req),
        .exc_cause(exc_cause), .trap_num(trap_num), .cur_pc(cur_pc),
        .cur_ipl(cur_ipl), .priv_mode(priv_mode), .base_addr(base_addr),
        .new_pc(new_pc), .exc_addr(exc_addr), .priv_out(priv_out),
        .taken(taken), .cause_err(cause_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic run_vec(input string tag, input logic req, input logic [3:0] cause,
                           input logic [7:0] tn, input logic [3:0] irq, input logic [2:0] ipl,
                           input logic priv, input logic [PCW-1:0] pc, input logic [PCW-1:0] base);
        logic e_take, e_err;
        int   ofs;
        e_take = 1'b0; e_err = 1'b0; ofs = 0;
        if (req) begin
            if (cause < 10)       begin e_take = 1'b1; ofs = int'(cause) * 128; end
            else if (cause == 10) begin
                e_take = 1'b1;
                ofs = tn[7] ? 'h2000 + (int'(tn) - 'h80) * 64 : 'h1000 + int'(tn) * 64;
            end
            else e_err = 1'b1;
        end else if (!priv) begin
            if      (irq[3] && ipl <= 6) begin e_take = 1'b1; ofs = 'h080; end
            else if (irq[2] && ipl <= 5) begin e_take = 1'b1; ofs = 'h100; end
            else if (irq[1] && ipl <= 4) begin e_take = 1'b1; ofs = 'h180; end
            else if (irq[0] && ipl <= 3) begin e_take = 1'b1; ofs = 'h200; end
        end
        @(negedge clk);
        exc_req = req; exc_cause = cause; trap_num = tn; irq_pend = irq;
        cur_ipl = ipl; priv_mode = priv; cur_pc = pc; base_addr = base;
        @(posedge clk); #1;
        if (e_take) begin
            exp_pc = base + PCW'(ofs);
            exp_ea = pc | PCW'(priv);
        end
        check(taken == e_take, tag, "taken", 64'(taken), 64'(e_take));
        check(new_pc == exp_pc, tag, "new_pc", 64'(new_pc), 64'(exp_pc));
        check(exc_addr == exp_ea, "R7", "exc_addr", 64'(exc_addr), 64'(exp_ea));
        check(priv_out == (e_take | priv), "R8", "priv_out", 64'(priv_out), 64'(e_take | priv));
        check(cause_err == e_err, "R11", "cause_err", 64'(cause_err), 64'(e_err));
        @(negedge clk);
        exc_req = 1'b0; irq_pend = '0;
        @(posedge clk);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values
        check(taken == 1'b0, "R1", "taken", 64'(taken), 0);
        check(cause_err == 1'b0, "R1", "cause_err", 64'(cause_err), 0);
        check(new_pc == '0, "R1", "new_pc", 64'(new_pc), 0);
        check(exc_addr == '0, "R1", "exc_addr", 64'(exc_addr), 0);
        check(priv_out == 1'b1, "R1", "priv_out", 64'(priv_out), 1);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);

        // R2 R3 R4 R12: every pending pattern at every IPL and mode
        for (int p = 0; p < 2; p++)
            for (int l = 0; l < 8; l++)
                for (int m = 0; m < 16; m++)
                    run_vec(p != 0 ? "R4" : ($countones(4'(m)) > 1 ? "R3" : "R2"),
                            1'b0, 4'd0, 8'd0, 4'(m), 3'(l), 1'(p),
                            PCW'(32'h0040_0000 + m * 16 + l * 4 + p),
                            PCW'(32'h0001_0000 * (l + 1)));

        // R5 R11 R12: every cause code, both modes, incl. a wrapping base
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < 16; c++) begin
                run_vec(c > 10 ? "R11" : (c == 10 ? "R6" : "R5"),
                        1'b1, 4'(c), 8'h05, 4'h0, 3'd0, 1'(p),
                        PCW'(32'h1234_5670 + c * 4), PCW'(32'h0800_0000));
                run_vec(c > 10 ? "R11" : (c == 10 ? "R6" : "R5"),
                        1'b1, 4'(c), 8'h85, 4'h0, 3'd7, 1'(p),
                        PCW'(32'h0000_1001), PCW'(32'hFFFF_FF00));
            end

        // R6: every call-trap number
        for (int n = 0; n < 256; n++)
            run_vec("R6", 1'b1, 4'd10, 8'(n), 4'h0, 3'd2, 1'(n % 2),
                    PCW'(32'h0002_0000 + n * 8), PCW'(32'h0010_0000));

        // R9: exception beats every interrupt, unknown cause blocks them too
        run_vec("R9", 1'b1, 4'd8, 8'd0, 4'hF, 3'd0, 1'b0, PCW'(32'h0000_0A00), PCW'(32'h0300_0000));
        run_vec("R9", 1'b1, 4'd0, 8'd0, 4'hF, 3'd0, 1'b0, PCW'(32'h0000_0B00), PCW'(32'h0310_0000));
        run_vec("R11", 1'b1, 4'd13, 8'd0, 4'hF, 3'd0, 1'b0, PCW'(32'h0000_0C00), PCW'(32'h0320_0000));

        // R10: second request in the cycle after a take is ignored
        run_vec("R10", 1'b0, 4'd0, 8'd0, 4'h0, 3'd0, 1'b0, PCW'(32'h0000_0000), PCW'(32'h0400_0000));
        @(negedge clk);
        exc_req = 1'b1; exc_cause = 4'd5; irq_pend = 4'h0; priv_mode = 1'b0;
        cur_pc = PCW'(32'h0000_5000); base_addr = PCW'(32'h0500_0000);
        @(posedge clk); #1;
        check(taken == 1'b1, "R10", "first taken", 64'(taken), 1);
        check(new_pc == PCW'(32'h0500_0280), "R10", "first new_pc", 64'(new_pc), 64'h0500_0280);
        @(negedge clk);
        exc_cause = 4'd6; irq_pend = 4'hF; base_addr = PCW'(32'h0600_0000);
        @(posedge clk); #1;
        check(taken == 1'b0, "R10", "dead-cycle taken", 64'(taken), 0);
        check(new_pc == PCW'(32'h0500_0280), "R10", "dead-cycle new_pc", 64'(new_pc), 64'h0500_0280);
        @(negedge clk);
        exc_req = 1'b0; irq_pend = 4'h0;
        @(posedge clk); #1;
        check(taken == 1'b0, "R10", "after dead taken", 64'(taken), 0);
        check(new_pc == PCW'(32'h0500_0280), "R10", "after dead new_pc", 64'(new_pc), 64'h0500_0280);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule